// File: doc/BRIEF.md
# PoE Port Operating Mode Controller

This block is the control state machine for a single power-sourcing Ethernet port. It decides when the port runs a detection measurement or a classification measurement. It also decides when port power is switched on and when it is switched off. The measurement circuits, the fault timers and the host register bus sit outside the block. They reach it as plain strobes and levels.

The host picks one of four policies through a two-bit mode field, and may rewrite that field at any time:

- **Shutdown** disables the port and wipes its flags.
- **Manual** performs one measurement per host request and powers the port only on command.
- **Semi-automatic** loops detection and classification until the host asks for power.
- **Automatic** powers the port by itself once a good detection is followed by a finished classification.

A strap input selects the mode loaded by reset. Faults, an optional unplug condition and host power-off requests always take power away.

Top module: `poe_port_ctrl`

## Requirements
- R1: The mode field is encoded as 00 Shutdown, 01 Manual, 10 Semi-automatic, 11 Automatic. A write on `mode_wr` loads `mode_wdata` on the next clock edge, in any state.
- R2: While `rst_n` is low, power is off and all flags are zero. The mode becomes 11 if `auto_strap` is high and 00 if it is low, and the unplug-enable bit `dcen` takes the value of `auto_strap`.
- R3: In Manual mode the port never starts a measurement on its own. A `det_req` starts exactly one detection cycle and a `cls_req` starts exactly one classification cycle. Each start is marked by a single-cycle strobe. The result and an event bit are stored when the matching done strobe arrives.
- R4: In Manual mode, `pwr_on_req` turns power on in the next cycle, even while a measurement is pending and even if the last detection failed.
- R5: In Semi-automatic mode detection, then classification, repeats without host action. Power turns on only after `pwr_on_req`, and only when the stored detection result is good.
- R6: In Automatic mode a good detection leads to classification. Power turns on in the cycle after `cls_done`, whatever the class code. A bad detection leads to a new detection attempt.
- R7: In Shutdown mode no strobe is issued and power stays off. Entering Shutdown clears the event bits, the detection and class results, and `dcen`. While in Shutdown, power-on requests and `dcen` writes are ignored.
- R8: In every mode, `fault_start` or `fault_cut` while powered removes power on the next edge and sets `evt_fault`.
- R9: While powered, `unplug` removes power and sets `evt_unplug` only if `dcen` is 1. Otherwise it has no effect.
- R10: `pwr_off_req` forces power off on the next edge in any state. When it arrives together with `pwr_on_req`, power ends up off.
- R11: After power is removed, the port idles for its mode. Manual mode then waits for a request. Semi-automatic and Automatic modes start a new detection in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_strap | input | 1 | Strap selecting the reset mode |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | New mode value |
| dcen_wr | input | 1 | Unplug-enable write strobe |
| dcen_wdata | input | 1 | New unplug-enable value |
| pwr_on_req | input | 1 | Host power-on pulse |
| pwr_off_req | input | 1 | Host power-off pulse |
| det_req | input | 1 | Manual detection request pulse |
| cls_req | input | 1 | Manual classification request pulse |
| det_done | input | 1 | Detection finished strobe |
| det_good | input | 1 | Detection result, valid with det_done |
| cls_done | input | 1 | Classification finished strobe |
| cls_code | input | CLS_W | Class result, valid with cls_done |
| fault_start | input | 1 | Start-timeout fault |
| fault_cut | input | 1 | Overcurrent-timeout fault |
| unplug | input | 1 | Disconnect indication |
| mode | output | 2 | Current mode |
| dcen | output | 1 | Unplug-enable bit |
| det_start | output | 1 | Detection start strobe |
| cls_start | output | 1 | Classification start strobe |
| pwr_en | output | 1 | Port power enable |
| det_ok | output | 1 | Last detection result |
| cls_val | output | CLS_W | Last class result |
| evt_det | output | 1 | Detection-done event |
| evt_cls | output | 1 | Classification-done event |
| evt_fault | output | 1 | Fault power-removal event |
| evt_unplug | output | 1 | Unplug power-removal event |

## Verification
An automatic-mode vector table alternates failed detections, good detections and finished classifications with unplug, overcurrent and host power-off events. This separates a retry after a bad result from the power-on path, and shows the re-detection that follows each power loss. Directed runs cover the remaining cases:

- Strap-low reset.
- Manual requests, with power-on issued while a detection is still pending.
- Simultaneous on and off requests.
- A semi-automatic power-on refused before a good detection and accepted after it.
- Unplug with the enable bit off and then on.
- A shutdown write from the powered state, which must clear every flag.

// File: rtl/poe_port_ctrl.sv
module poe_port_ctrl #(
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_strap,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             dcen_wr,
  input  logic             dcen_wdata,
  input  logic             pwr_on_req,
  input  logic             pwr_off_req,
  input  logic             det_req,
  input  logic             cls_req,
  input  logic             det_done,
  input  logic             det_good,
  input  logic             cls_done,
  input  logic [CLS_W-1:0] cls_code,
  input  logic             fault_start,
  input  logic             fault_cut,
  input  logic             unplug,
  output logic [1:0]       mode,
  output logic             dcen,
  output logic             det_start,
  output logic             cls_start,
  output logic             pwr_en,
  output logic             det_ok,
  output logic [CLS_W-1:0] cls_val,
  output logic             evt_det,
  output logic             evt_cls,
  output logic             evt_fault,
  output logic             evt_unplug
);
  localparam logic [1:0] M_SHUT = 2'b00, M_MAN = 2'b01, M_SEMI = 2'b10, M_AUTO = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_DET, S_CLS, S_PWR} st_t;
  st_t st, st_nx;

  logic fault, powered, drop, to_shut, in_shut, on_ok;

  assign fault   = fault_start | fault_cut;
  assign powered = (st == S_PWR);
  assign drop    = powered && (pwr_off_req || fault || (unplug && dcen));
  assign to_shut = mode_wr && (mode_wdata == M_SHUT);
  assign in_shut = (mode == M_SHUT) && !mode_wr;
  assign on_ok   = pwr_on_req && !pwr_off_req && ((mode == M_MAN) || det_ok);
  assign pwr_en  = powered;

  always_comb begin
    st_nx = st;
    if (in_shut)
      st_nx = S_IDLE;
    else if (mode_wr)
      st_nx = (powered && !drop && !to_shut) ? S_PWR : S_IDLE;
    else if (powered)
      st_nx = drop ? S_IDLE : S_PWR;
    else if (pwr_off_req)
      st_nx = S_IDLE;
    else if (on_ok)
      st_nx = S_PWR;
    else begin
      case (st)
        S_IDLE:
          if (mode == M_MAN) st_nx = det_req ? S_DET : (cls_req ? S_CLS : S_IDLE);
          else               st_nx = S_DET;
        S_DET:
          if (det_done) st_nx = (mode != M_MAN && det_good) ? S_CLS : S_IDLE;
        S_CLS:
          if (cls_done) st_nx = (mode == M_AUTO) ? S_PWR : S_IDLE;
        default: st_nx = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode       <= auto_strap ? M_AUTO : M_SHUT;
      dcen       <= auto_strap;
      det_start  <= 1'b0;
      cls_start  <= 1'b0;
      det_ok     <= 1'b0;
      cls_val    <= '0;
      evt_det    <= 1'b0;
      evt_cls    <= 1'b0;
      evt_fault  <= 1'b0;
      evt_unplug <= 1'b0;
    end else begin
      st        <= st_nx;
      det_start <= (st_nx == S_DET) && (st != S_DET);
      cls_start <= (st_nx == S_CLS) && (st != S_CLS);
      if (mode_wr) mode <= mode_wdata;
      if (to_shut || in_shut) begin
        dcen       <= 1'b0;
        det_ok     <= 1'b0;
        cls_val    <= '0;
        evt_det    <= 1'b0;
        evt_cls    <= 1'b0;
        evt_fault  <= 1'b0;
        evt_unplug <= 1'b0;
      end else begin
        if (dcen_wr) dcen <= dcen_wdata;
        if (st == S_DET && det_done) begin
          det_ok  <= det_good;
          evt_det <= 1'b1;
        end
        if (st == S_CLS && cls_done) begin
          cls_val <= cls_code;
          evt_cls <= 1'b1;
        end
        if (powered && fault) evt_fault <= 1'b1;
        if (powered && unplug && dcen) evt_unplug <= 1'b1;
      end
    end
  end

  a_r7_shut_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SHUT) |-> (!pwr_en && !det_start && !cls_start));
  a_r8_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && fault) |=> !pwr_en);
  a_r9_unplug_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && unplug && dcen) |=> !pwr_en);
  a_r10_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> !pwr_en);
  a_r3_one_det_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    det_start |=> !det_start);
  a_r5_semi_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SEMI && !pwr_en && !pwr_on_req) |=> !pwr_en);
endmodule

// File: tb/poe_port_ctrl_tb.sv
`timescale 1ns/1ps
module poe_port_ctrl_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, auto_strap, mode_wr, dcen_wr, dcen_wdata;
  logic pwr_on_req, pwr_off_req, det_req, cls_req, det_done, det_good, cls_done;
  logic fault_start, fault_cut, unplug;
  logic [1:0] mode_wdata, mode;
  logic [2:0] cls_code, cls_val;
  logic dcen, det_start, cls_start, pwr_en, det_ok, evt_det, evt_cls, evt_fault, evt_unplug;
  int checks = 0, errors = 0;
  bit done = 0;

  poe_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .auto_strap(auto_strap), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .dcen_wr(dcen_wr), .dcen_wdata(dcen_wdata),
    .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req), .det_req(det_req),
    .cls_req(cls_req), .det_done(det_done), .det_good(det_good), .cls_done(cls_done),
    .cls_code(cls_code), .fault_start(fault_start), .fault_cut(fault_cut),
    .unplug(unplug), .mode(mode), .dcen(dcen), .det_start(det_start),
    .cls_start(cls_start), .pwr_en(pwr_en), .det_ok(det_ok), .cls_val(cls_val),
    .evt_det(evt_det), .evt_cls(evt_cls), .evt_fault(evt_fault), .evt_unplug(evt_unplug));

  // stim bits: [7]on [6]off [5]det_done [4]det_good [3]cls_done [2]fault_cut [1]unplug
  localparam int NV = 18;
  localparam logic [7:0] STIM [NV] = '{8'h00, 8'h00, 8'h20, 8'h00, 8'h30, 8'h00,
    8'h08, 8'h00, 8'h02, 8'h00, 8'h30, 8'h08, 8'h04, 8'h00, 8'h30, 8'h08, 8'h40, 8'h00};
  // expected {pwr_en, det_start, cls_start}
  localparam logic [2:0] EXPV [NV] = '{3'd2, 3'd0, 3'd0, 3'd2, 3'd1, 3'd0,
    3'd4, 3'd4, 3'd0, 3'd2, 3'd1, 3'd4, 3'd0, 3'd2, 3'd1, 3'd4, 3'd0, 3'd2};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    mode_wr = 0; dcen_wr = 0; pwr_on_req = 0; pwr_off_req = 0; det_req = 0;
    cls_req = 0; det_done = 0; det_good = 0; cls_done = 0;
    fault_start = 0; fault_cut = 0; unplug = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    clr();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr(); mode_wdata = 0; dcen_wdata = 0; cls_code = 3'd2;
    auto_strap = 1; rst_n = 0;
    step(); step();
    chk("R2 mode strap high", mode, 3);
    chk("R2 pwr off", pwr_en, 0);
    chk("R2 dcen strap high", dcen, 1);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      pwr_on_req = STIM[i][7]; pwr_off_req = STIM[i][6]; det_done = STIM[i][5];
      det_good = STIM[i][4]; cls_done = STIM[i][3]; fault_cut = STIM[i][2];
      unplug = STIM[i][1];
      @(posedge clk); #2; clr();
      chk($sformatf("R6/R8/R9/R10/R11 vector %0d", i), {pwr_en, det_start, cls_start}, EXPV[i]);
    end
    chk("R9 unplug event", evt_unplug, 1);

    // strap low reset, shutdown quiet
    auto_strap = 0; rst_n = 0; step(); step();
    chk("R2 mode strap low", mode, 0);
    chk("R2 dcen strap low", dcen, 0);
    chk("R2 pwr off low", pwr_en, 0);
    rst_n = 1;
    step(); step();
    chk("R7 no detect in shutdown", det_start, 0);
    pwr_on_req = 1; step();
    chk("R7 power-on ignored", pwr_en, 0);
    dcen_wr = 1; dcen_wdata = 1; step();
    chk("R7 dcen write ignored", dcen, 0);

    // manual
    mode_wr = 1; mode_wdata = 2'b01; step();
    chk("R1 mode manual", mode, 1);
    step(); step();
    chk("R3 manual no autonomous detect", det_start, 0);
    det_req = 1; step();
    chk("R3 det strobe", det_start, 1);
    step();
    chk("R3 det strobe single", det_start, 0);
    det_done = 1; det_good = 0; step();
    chk("R3 evt_det", evt_det, 1);
    chk("R3 det_ok bad", det_ok, 0);
    step();
    chk("R3 no repeat detect", det_start, 0);
    cls_req = 1; step();
    chk("R3 cls strobe", cls_start, 1);
    cls_done = 1; cls_code = 3'd5; step();
    chk("R3 cls value", cls_val, 5);
    chk("R3 evt_cls", evt_cls, 1);
    det_req = 1; step();
    pwr_on_req = 1; step();
    chk("R4 power-on during detection", pwr_en, 1);
    pwr_on_req = 1; pwr_off_req = 1; step();
    chk("R10 off wins when powered", pwr_en, 0);
    pwr_on_req = 1; pwr_off_req = 1; step();
    chk("R10 off wins when idle", pwr_en, 0);
    pwr_on_req = 1; step();
    chk("R4 manual power-on", pwr_en, 1);
    fault_start = 1; step();
    chk("R8 start fault drops", pwr_en, 0);
    chk("R8 evt_fault", evt_fault, 1);
    step();
    chk("R11 manual idles", {pwr_en, det_start}, 0);

    // semi-automatic
    mode_wr = 1; mode_wdata = 2'b10; step();
    step();
    chk("R5 semi detect start", det_start, 1);
    pwr_on_req = 1; step();
    chk("R5 power-on refused without good detect", pwr_en, 0);
    det_done = 1; det_good = 1; step();
    chk("R5 semi classify", cls_start, 1);
    cls_done = 1; step();
    chk("R5 semi no auto power", pwr_en, 0);
    step();
    chk("R5 semi repeats detect", det_start, 1);
    pwr_on_req = 1; step();
    chk("R5 semi power-on accepted", pwr_en, 1);
    unplug = 1; step();
    chk("R9 unplug masked", pwr_en, 1);
    chk("R9 no unplug event", evt_unplug, 0);
    dcen_wr = 1; dcen_wdata = 1; step();
    unplug = 1; step();
    chk("R9 unplug enabled drops", pwr_en, 0);
    chk("R9 unplug event set", evt_unplug, 1);
    step();
    pwr_on_req = 1; step();
    chk("R5 repower", pwr_en, 1);
    mode_wr = 1; mode_wdata = 2'b00; step();
    chk("R7 shutdown drops power", pwr_en, 0);
    chk("R7 clears flags", {evt_det, evt_cls, evt_fault, evt_unplug, det_ok, dcen}, 0);
    chk("R7 clears class", cls_val, 0);
    chk("R1 mode shutdown", mode, 0);

    // automatic with overcurrent
    mode_wr = 1; mode_wdata = 2'b11; cls_code = 3'd0; step();
    step();
    chk("R6 auto detect", det_start, 1);
    det_done = 1; det_good = 1; step();
    cls_done = 1; step();
    chk("R6 auto power class 0", pwr_en, 1);
    fault_cut = 1; step();
    chk("R8 overcurrent drops", pwr_en, 0);
    chk("R8 overcurrent event", evt_fault, 1);
    step();
    chk("R11 auto redetects", det_start, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule